// File: doc/BRIEF.md
# Selectable Lane Event Counter

This block counts one chosen kind of link event on one chosen lane of a serial link controller. Event sources in the link layers raise single-cycle strobes, one per event kind and per lane. Software picks the event through a two-level selection: a group number and an event number within that group. It also picks a lane, and it starts, stops and clears the count through command codes in one control word.

The block has a small synchronous register port. A write is taken on the rising clock edge when the write strobe is high. Read data is a combinational function of the address. There are two registers, a control word and a read-only count word. The count is never zeroed as a side effect of starting or stopping. It only returns to zero through an explicit clear command or reset.

Top module: `lnevt_cnt`

## Requirements
- R1: After reset the count word reads 0, counting is off, and the control word reads 0x0000_0004 (all selections 0, enable field showing the off code).
- R2: The control word sits at offset 0x8. It holds the group in bits 27:24, the event within the group in bits 23:16, the lane in bits 11:8, a status bit 7, the enable field in bits 4:2 and the clear field in bits 1:0. Bits 7 and 4:2 read back 1 and 0x3 while counting and 0 and 0x1 while stopped. Unused bits read 0.
- R3: Writing enable code 0x3 turns counting on and enable code 0x1 turns it off. Any other enable code leaves the on/off state unchanged.
- R4: While counting is on, the count word at offset 0xC rises by one on each clock edge at which the selected strobe is high. While counting is off it holds its value.
- R5: Only the strobe at index (lane*NUM_GRP + group)*NUM_EVT + event is counted. A new selection is used from the clock edge after the one that takes the write.
- R6: Writing clear code 0x1 zeroes the count on the clock edge after the write. In the cycle between those two edges the clear field reads 0x1, and it reads 0 afterwards. Clear codes 0x0, 0x2 and 0x3 do not clear.
- R7: When a clear and a counted strobe meet on the same edge, the count becomes 0.
- R8: Turning counting off and then on again keeps the accumulated count.
- R9: The count wraps from all ones to zero (modulo 2^CNT_W).
- R10: A group at or above NUM_GRP, an event at or above NUM_EVT, or a lane at or above NUM_LANES counts nothing.
- R11: Writes to the count word or to any other offset leave the control state and the count unchanged. Reads of any other offset return 0.
- R12: A single control write updates selection, enable and clear together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_stb | input | NUM_LANES*NUM_GRP*NUM_EVT | Event strobes, index (lane*NUM_GRP+group)*NUM_EVT+event |

## Verification
The situation hardest to reach from the ports is the wrap of the 32-bit count, because counting up to 2^32 events is far beyond any run length. The bench therefore builds a second instance with an 8-bit count and drives its selected strobe for 260 edges, so the wrap is observed at the port. The other delicate point is the one-cycle window around a clear. The bench reads the clear field and the count in the cycle right after the clearing write, and it holds the strobe high through that window, so both the self-clearing readback and the priority of clear over increment are seen.

// File: rtl/lnevt_pkg.sv
package lnevt_pkg;

   // control word layout (fields decoded by software, positions fixed)
   localparam int GRP_LSB  = 24;
   localparam int EVT_LSB  = 16;
   localparam int LANE_LSB = 8;
   localparam int STAT_BIT = 7;
   localparam int EN_LSB   = 2;
   localparam int CLR_LSB  = 0;

   localparam int GRP_W  = 4;
   localparam int EVT_W  = 8;
   localparam int LANE_W = 4;
   localparam int EN_W   = 3;
   localparam int CLR_W  = 2;

   localparam int CTL_OFS = 'h8;
   localparam int DAT_OFS = 'hC;

   localparam logic [EN_W-1:0]  EN_ON   = 3'h3;
   localparam logic [EN_W-1:0]  EN_OFF  = 3'h1;
   localparam logic [CLR_W-1:0] CLR_GO  = 2'h1;

   typedef struct packed {
      logic [GRP_W-1:0]  grp;
      logic [EVT_W-1:0]  evt;
      logic [LANE_W-1:0] lane;
   } lnevt_sel_t;

endpackage

// File: rtl/lnevt_regs.sv
module lnevt_regs
   import lnevt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [CNT_W-1:0]  cnt,
   output lnevt_sel_t        sel,
   output logic              en,
   output logic              clr,
   output logic [31:0]       rdata
);

   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS);
   localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DAT_OFS);

   logic              ctl_wr;
   logic [EN_W-1:0]   en_code;
   logic [CLR_W-1:0]  clr_code;

   assign ctl_wr   = wr && (addr == A_CTL);
   assign en_code  = wdata[EN_LSB +: EN_W];
   assign clr_code = wdata[CLR_LSB +: CLR_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel <= '0;
         en  <= 1'b0;
         clr <= 1'b0;
      end else begin
         clr <= ctl_wr && (clr_code == CLR_GO);
         if (ctl_wr) begin
            sel.grp  <= wdata[GRP_LSB +: GRP_W];
            sel.evt  <= wdata[EVT_LSB +: EVT_W];
            sel.lane <= wdata[LANE_LSB +: LANE_W];
            if (en_code == EN_ON)
               en <= 1'b1;
            else if (en_code == EN_OFF)
               en <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CTL) begin
         rdata[GRP_LSB +: GRP_W]   = sel.grp;
         rdata[EVT_LSB +: EVT_W]   = sel.evt;
         rdata[LANE_LSB +: LANE_W] = sel.lane;
         rdata[STAT_BIT]           = en;
         rdata[EN_LSB +: EN_W]     = en ? EN_ON : EN_OFF;
         rdata[CLR_LSB +: CLR_W]   = clr ? CLR_GO : '0;
      end else if (addr == A_DAT) begin
         rdata = 32'(cnt);
      end
   end

endmodule

// File: rtl/lnevt_route.sv
module lnevt_route
   import lnevt_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int NUM_GRP   = 2,
   parameter int NUM_EVT   = 4
)(
   input  logic [NUM_LANES*NUM_GRP*NUM_EVT-1:0] evt_stb,
   input  lnevt_sel_t                           sel,
   output logic                                 hit
);

   localparam int PER_LANE  = NUM_GRP * NUM_EVT;
   localparam int LANE_SLOT = 1 << LANE_W;

   logic                 src_ok;
   int                   src_idx;
   logic [LANE_SLOT-1:0] lane_hit;

   always_comb begin
      src_ok  = (int'(sel.grp) < NUM_GRP) && (int'(sel.evt) < NUM_EVT);
      src_idx = src_ok ? (int'(sel.grp) * NUM_EVT + int'(sel.evt)) : 0;
   end

   for (genvar l = 0; l < LANE_SLOT; l++) begin : g_lane
      if (l < NUM_LANES) begin : g_real
         logic [PER_LANE-1:0] vec;
         assign vec         = evt_stb[l*PER_LANE +: PER_LANE];
         assign lane_hit[l] = src_ok && vec[src_idx];
      end else begin : g_pad
         assign lane_hit[l] = 1'b0;
      end
   end

   assign hit = lane_hit[sel.lane];

endmodule

// File: rtl/lnevt_acc.sv
module lnevt_acc #(
   parameter int CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (en && inc)
         cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/lnevt_cnt.sv
module lnevt_cnt
   import lnevt_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int NUM_GRP   = 2,
   parameter int NUM_EVT   = 4,
   parameter int CNT_W     = 32,
   parameter int ADDR_W    = 8
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 reg_wr,
   input  logic [ADDR_W-1:0]                    reg_addr,
   input  logic [31:0]                          reg_wdata,
   output logic [31:0]                          reg_rdata,
   input  logic [NUM_LANES*NUM_GRP*NUM_EVT-1:0] evt_stb
);

   if (NUM_LANES < 1 || NUM_LANES > (1 << LANE_W)) begin : g_bad_lanes
      $error("lnevt_cnt: NUM_LANES out of range");
   end
   if (NUM_GRP < 1 || NUM_GRP > 8) begin : g_bad_grp
      $error("lnevt_cnt: NUM_GRP out of range");
   end
   if (NUM_EVT < 1 || NUM_EVT > (1 << EVT_W)) begin : g_bad_evt
      $error("lnevt_cnt: NUM_EVT out of range");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("lnevt_cnt: CNT_W out of range");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("lnevt_cnt: ADDR_W too narrow for register offsets");
   end

   lnevt_sel_t       sel_q;
   logic             en_q;
   logic             clr_q;
   logic             hit;
   logic [CNT_W-1:0] cnt_q;

   lnevt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .cnt   (cnt_q),
      .sel   (sel_q),
      .en    (en_q),
      .clr   (clr_q),
      .rdata (reg_rdata)
   );

   lnevt_route #(.NUM_LANES(NUM_LANES), .NUM_GRP(NUM_GRP), .NUM_EVT(NUM_EVT)) u_route (
      .evt_stb (evt_stb),
      .sel     (sel_q),
      .hit     (hit)
   );

   lnevt_acc #(.CNT_W(CNT_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_q),
      .en    (en_q),
      .inc   (hit),
      .cnt   (cnt_q)
   );

endmodule

// File: rtl/lnevt_cnt_chk.sv
module lnevt_cnt_chk
   import lnevt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              en_q,
   input logic              clr_q,
   input logic              hit,
   input logic [CNT_W-1:0]  cnt_q
);

   logic ctl_wr;
   assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(CTL_OFS));

   // R6: a pending clear zeroes the count on the next edge
   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |=> (cnt_q == '0));

   // R6: the clear indication lasts one cycle unless a new write arrives
   p_clear_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_q && !ctl_wr) |=> !clr_q);

   // R4: stopped and not clearing means the count holds
   p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !clr_q) |=> $stable(cnt_q));

   // R4: running, the count moves by the strobe seen at the previous edge
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !clr_q) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(hit))));

   // R3: on code starts counting
   p_en_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && reg_wdata[EN_LSB +: EN_W] == EN_ON) |=> en_q);

   // R3: off code stops counting
   p_en_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && reg_wdata[EN_LSB +: EN_W] == EN_OFF) |=> !en_q);

   // R11: without a control write the on/off state is stable
   p_en_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(en_q));

endmodule

bind lnevt_cnt lnevt_cnt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .en_q      (en_q),
   .clr_q     (clr_q),
   .hit       (hit),
   .cnt_q     (cnt_q)
);

// File: tb/lnevt_cnt_test.sv
`timescale 1ns/1ps
module lnevt_cnt_test;

   localparam int NL = 4;
   localparam int NG = 2;
   localparam int NE = 4;
   localparam int SW = NL*NG*NE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic          wr2 = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [31:0]   rdata2;
   logic [SW-1:0] stb = '0;
   logic [SW-1:0] stb2 = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   lnevt_cnt #(.NUM_LANES(NL), .NUM_GRP(NG), .NUM_EVT(NE), .CNT_W(32), .ADDR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .evt_stb(stb));

   lnevt_cnt #(.NUM_LANES(NL), .NUM_GRP(NG), .NUM_EVT(NE), .CNT_W(8), .ADDR_W(8)) uut_nar (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr2), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata2), .evt_stb(stb2));

   function automatic int sidx(input int lane, input int grp, input int evt);
      return (lane*NG + grp)*NE + evt;
   endfunction

   function automatic logic [31:0] mk(input int grp, input int evt, input int lane,
                                      input int en, input int clr);
      return (32'(grp) << 24) | (32'(evt) << 16) | (32'(lane) << 8) |
             (32'(en) << 2) | 32'(clr);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wreg(input bit nar, input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d;
      if (nar) wr2 = 1'b1; else wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; wr2 = 1'b0;
   endtask

   task automatic rreg(input bit nar, input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = nar ? rdata2 : rdata;
   endtask

   task automatic pulse(input int i, input int n);
      stb[i] = 1'b1;
      cyc(n);
      stb = '0;
   endtask

   logic [31:0] v;

   task automatic t_reset();
      rreg(0, 8'h8, v);  chk("R1 control after reset", v, 32'h4);
      rreg(0, 8'hC, v);  chk("R1 count after reset", v, 0);
   endtask

   task automatic t_fields();
      wreg(0, 8'h8, mk(1, 2, 3, 3, 0));
      rreg(0, 8'h8, v);  chk("R2 R12 field readback", v, 32'h0102_038C);
      wreg(0, 8'h8, mk(0, 0, 0, 1, 0));
      rreg(0, 8'h8, v);  chk("R2 readback when stopped", v, 32'h4);
   endtask

   task automatic t_count();
      wreg(0, 8'h8, mk(0, 0, 0, 3, 0));
      pulse(sidx(0, 0, 0), 5);
      rreg(0, 8'hC, v);  chk("R4 counts selected strobe", v, 5);
      pulse(sidx(0, 0, 1), 4);
      pulse(sidx(1, 0, 0), 4);
      rreg(0, 8'hC, v);  chk("R5 other sources ignored", v, 5);
   endtask

   task automatic t_onoff();
      wreg(0, 8'h8, mk(0, 0, 0, 1, 0));
      pulse(sidx(0, 0, 0), 3);
      rreg(0, 8'hC, v);  chk("R4 holds while stopped", v, 5);
      wreg(0, 8'h8, mk(0, 0, 0, 2, 0));
      rreg(0, 8'h8, v);  chk("R3 code 2 keeps off", v, 32'h4);
      wreg(0, 8'h8, mk(0, 0, 0, 3, 0));
      rreg(0, 8'hC, v);  chk("R8 re-enable keeps count", v, 5);
      wreg(0, 8'h8, mk(0, 0, 0, 7, 0));
      rreg(0, 8'h8, v);  chk("R3 code 7 keeps on", v, 32'h8C);
      pulse(sidx(0, 0, 0), 2);
      rreg(0, 8'hC, v);  chk("R8 continues from kept count", v, 7);
   endtask

   task automatic t_clear();
      wreg(0, 8'h8, mk(0, 0, 0, 3, 2));
      wreg(0, 8'h8, mk(0, 0, 0, 3, 3));
      wreg(0, 8'h8, mk(0, 0, 0, 3, 0));
      cyc(1);
      rreg(0, 8'hC, v);  chk("R6 codes 0/2/3 do not clear", v, 7);
      wreg(0, 8'h8, mk(0, 0, 0, 3, 1));
      rreg(0, 8'h8, v);  chk("R6 clear field set in window", v[1:0], 2'h1);
      rreg(0, 8'hC, v);  chk("R6 count before clear edge", v, 7);
      cyc(1);
      rreg(0, 8'h8, v);  chk("R6 clear field self-clears", v[1:0], 2'h0);
      rreg(0, 8'hC, v);  chk("R6 count cleared", v, 0);
   endtask

   task automatic t_prio();
      pulse(sidx(0, 0, 0), 3);
      wreg(0, 8'h8, mk(0, 0, 0, 3, 1));
      pulse(sidx(0, 0, 0), 3);
      rreg(0, 8'hC, v);  chk("R7 clear beats increment", v, 2);
   endtask

   task automatic t_switch();
      logic [31:0] c0;
      rreg(0, 8'hC, c0);
      stb[sidx(2, 1, 3)] = 1'b1;
      wreg(0, 8'h8, mk(1, 3, 2, 3, 0));
      cyc(3);
      stb = '0;
      rreg(0, 8'hC, v);  chk("R5 selection effective next edge", v, c0 + 3);
   endtask

   task automatic t_invalid();
      logic [31:0] c0;
      rreg(0, 8'hC, c0);
      wreg(0, 8'h8, mk(2, 0, 0, 3, 0));
      stb = '1; cyc(4); stb = '0;
      rreg(0, 8'hC, v);  chk("R10 unpopulated group", v, c0);
      wreg(0, 8'h8, mk(0, 5, 0, 3, 0));
      stb = '1; cyc(4); stb = '0;
      rreg(0, 8'hC, v);  chk("R10 unpopulated event", v, c0);
      wreg(0, 8'h8, mk(0, 0, 4, 3, 0));
      stb = '1; cyc(4); stb = '0;
      rreg(0, 8'hC, v);  chk("R10 lane beyond count", v, c0);
      wreg(0, 8'h8, mk(1, 3, 3, 3, 0));
      pulse(sidx(3, 1, 3), 4);
      rreg(0, 8'hC, v);  chk("R5 highest valid source", v, c0 + 4);
   endtask

   task automatic t_ignore();
      logic [31:0] c0;
      logic [31:0] k0;
      rreg(0, 8'hC, c0);
      rreg(0, 8'h8, k0);
      wreg(0, 8'hC, 32'hDEAD_BEEF);
      rreg(0, 8'hC, v);  chk("R11 count word not writable", v, c0);
      wreg(0, 8'h10, mk(0, 0, 0, 1, 1));
      cyc(1);
      rreg(0, 8'h8, v);  chk("R11 stray write leaves control", v, k0);
      rreg(0, 8'hC, v);  chk("R11 stray write leaves count", v, c0);
      rreg(0, 8'h10, v); chk("R11 unmapped read", v, 0);
   endtask

   task automatic t_wrap();
      wreg(1, 8'h8, mk(0, 0, 0, 3, 0));
      stb2[sidx(0, 0, 0)] = 1'b1;
      cyc(260);
      stb2 = '0;
      rreg(1, 8'hC, v);  chk("R9 count wraps", v, 4);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_fields();
      t_count();
      t_onoff();
      t_clear();
      t_prio();
      t_switch();
      t_invalid();
      t_ignore();
      t_wrap();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule